// File: doc/BRIEF.md
# Serial Ferroelectric Memory Device Model

This block plays the device side of a byte-addressed serial ferroelectric memory on an SPI link, so a master controller can be exercised against it. It samples the serial clock, the active-low select and the master-to-device data line with a faster system clock. It decodes one command per select window and answers on the device-to-master line. It keeps a byte store, a status byte and a write-enable latch. Memory and status writes only take effect while that latch is set.

A command is an opcode byte, then a two-byte address (high byte first) for memory commands, then any number of data bytes. After each data byte the 15-bit address steps up by one and wraps at the top. Bursts have no page limit. The store has 2^STORE_AW bytes. When STORE_AW is below 15, the upper address bits alias onto the lower locations. The serial clock must stay slower than one quarter of the system clock so that the synchronizers see every edge. The link has no back-pressure: the master sets the pace, and the device keeps up at that rate.

Top module: `fram_spi_model`

## Requirements
- R1: After reset the data output is 0, the write-enable latch is clear, and a status read returns 0x00.
- R2: The link runs in SPI mode 3. MOSI is captured on rising serial-clock edges. MISO changes only after a falling edge, or goes to 0 while the select is high, MSB first.
- R3: Opcode 0x06 sets the write-enable latch. A status read then shows bit 1 as 1.
- R4: Opcode 0x04 clears the write-enable latch.
- R5: Opcode 0x02 followed by a high and then a low address byte writes each later data byte at the current address. The address increments after each byte.
- R6: Memory data bytes are discarded while the write-enable latch is clear.
- R7: When the select rises after a 0x02 or 0x01 command, the write-enable latch clears.
- R8: Opcode 0x01 with the latch set stores data bits 7:2 into the status byte. Without the latch the status byte is unchanged. A status read returns {stored bits 7:2, latch, 0}.
- R9: Opcode 0x03 followed by an address streams bytes from consecutive addresses. The address wraps from 0x7FFF to 0x0000.
- R10: Address bit 15 is ignored.
- R11: Opcode 0x05 returns the status byte repeatedly while the select stays low.
- R12: An unknown opcode, and any byte after 0x06 or 0x04, is ignored until the select rises. MISO stays 0, and memory, status and latch keep their values.
- R13: Raising the select in the middle of a byte discards that partial byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the link |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the master, idles high |
| cs_n | input | 1 | Active-low select; one command per low window |
| mosi | input | 1 | Master-to-device serial data |
| miso | output | 1 | Device-to-master serial data |

## Verification
Two situations are hard to reach from the pins: a select that rises in the middle of a byte, and an address counter that carries across 0x7FFF. The bench reaches the first with a transfer task that clocks only part of a byte before it releases the select, and then reads the target location back. It reaches the second by writing a two-byte burst that starts at 0x7FFF, then reading both the top location and location 0x0000. Unknown opcodes get a command-shaped byte sequence after them, so an ignored write that leaked through would change a known location.

// File: rtl/fram_pkg.sv
package fram_pkg;
  localparam logic [7:0] OP_WEL_SET = 8'h06;
  localparam logic [7:0] OP_WEL_CLR = 8'h04;
  localparam logic [7:0] OP_STAT_RD = 8'h05;
  localparam logic [7:0] OP_STAT_WR = 8'h01;
  localparam logic [7:0] OP_MEM_RD  = 8'h03;
  localparam logic [7:0] OP_MEM_WR  = 8'h02;

  typedef enum logic [2:0] {PH_OPC, PH_AHI, PH_ALO, PH_DATA, PH_SKIP} phase_t;
  typedef enum logic [2:0] {K_NONE, K_SRD, K_SWR, K_MRD, K_MWR} kind_t;
endpackage

// File: rtl/fram_pin_sync.sv
module fram_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_idle,
  output logic cs_rise,
  output logic mosi_s
);
  localparam logic [2:0] IDLE_VAL = 3'b110; // {sclk, cs_n, mosi}

  logic [2:0] pipe [STAGES];
  logic       sclk_d, cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= IDLE_VAL;
    else        pipe[0] <= {sclk, cs_n, mosi};
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[g] <= IDLE_VAL;
      else        pipe[g] <= pipe[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b1;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= pipe[STAGES-1][2];
      cs_d   <= pipe[STAGES-1][1];
    end
  end

  assign sclk_rise = pipe[STAGES-1][2] & ~sclk_d;
  assign sclk_fall = ~pipe[STAGES-1][2] & sclk_d;
  assign cs_idle   = pipe[STAGES-1][1];
  assign cs_rise   = pipe[STAGES-1][1] & ~cs_d;
  assign mosi_s    = pipe[STAGES-1][0];
endmodule

// File: rtl/fram_store.sv
module fram_store #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/fram_cmd_ctrl.sv
module fram_cmd_ctrl
  import fram_pkg::*;
#(
  parameter int ADDR_W   = 15,
  parameter int STORE_AW = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk_rise,
  input  logic                sclk_fall,
  input  logic                cs_idle,
  input  logic                cs_rise,
  input  logic                mosi_s,
  output logic                miso,
  output logic                mem_we,
  output logic [STORE_AW-1:0] mem_waddr,
  output logic [7:0]          mem_wdata,
  output logic [STORE_AW-1:0] mem_raddr,
  input  logic [7:0]          mem_rdata
);
  localparam int HI_W = ADDR_W - 8;

  logic [2:0]        bitcnt;
  logic [6:0]        shin;
  phase_t            phase;
  kind_t             kind;
  logic [ADDR_W-1:0] addr;
  logic              wel;
  logic [5:0]        sr_hi;
  logic [7:0]        txsh;
  logic              miso_q;

  logic              byte_done;
  logic [7:0]        rx_byte;
  logic [7:0]        status_byte;
  logic [ADDR_W-1:0] addr_inc, addr_load, raddr_full;

  assign byte_done   = sclk_rise && !cs_idle && (bitcnt == 3'd7);
  assign rx_byte     = {shin, mosi_s};
  assign status_byte = {sr_hi, wel, 1'b0};
  assign addr_inc    = addr + 1'b1;
  assign addr_load   = {addr[ADDR_W-1:8], rx_byte};
  assign raddr_full  = (phase == PH_ALO) ? addr_load : addr_inc;

  assign mem_we    = byte_done && (phase == PH_DATA) && (kind == K_MWR) && wel;
  assign mem_waddr = addr[STORE_AW-1:0];
  assign mem_wdata = rx_byte;
  assign mem_raddr = raddr_full[STORE_AW-1:0];
  assign miso      = miso_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt <= '0;
      shin   <= '0;
      phase  <= PH_OPC;
      kind   <= K_NONE;
      addr   <= '0;
      wel    <= 1'b0;
      sr_hi  <= '0;
      txsh   <= '0;
      miso_q <= 1'b0;
    end else if (cs_idle) begin
      bitcnt <= '0;
      phase  <= PH_OPC;
      kind   <= K_NONE;
      txsh   <= '0;
      miso_q <= 1'b0;
      if (cs_rise && (kind == K_MWR || kind == K_SWR)) wel <= 1'b0;
    end else begin
      if (sclk_fall) begin
        miso_q <= txsh[7];
        txsh   <= {txsh[6:0], 1'b0};
      end
      if (sclk_rise) begin
        shin   <= {shin[5:0], mosi_s};
        bitcnt <= bitcnt + 3'd1;
      end
      if (byte_done) begin
        unique case (phase)
          PH_OPC: begin
            unique case (rx_byte)
              OP_WEL_SET: begin wel <= 1'b1; phase <= PH_SKIP; end
              OP_WEL_CLR: begin wel <= 1'b0; phase <= PH_SKIP; end
              OP_STAT_RD: begin kind <= K_SRD; phase <= PH_DATA; txsh <= status_byte; end
              OP_STAT_WR: begin kind <= K_SWR; phase <= PH_DATA; end
              OP_MEM_RD:  begin kind <= K_MRD; phase <= PH_AHI; end
              OP_MEM_WR:  begin kind <= K_MWR; phase <= PH_AHI; end
              default:    phase <= PH_SKIP;
            endcase
          end
          PH_AHI: begin
            addr[ADDR_W-1:8] <= rx_byte[HI_W-1:0];
            phase            <= PH_ALO;
          end
          PH_ALO: begin
            addr  <= addr_load;
            phase <= PH_DATA;
            if (kind == K_MRD) txsh <= mem_rdata;
          end
          PH_DATA: begin
            unique case (kind)
              K_SRD: txsh <= status_byte;
              K_SWR: if (wel) sr_hi <= rx_byte[7:2];
              K_MRD: begin addr <= addr_inc; txsh <= mem_rdata; end
              K_MWR: addr <= addr_inc;
              default: ;
            endcase
          end
          default: ;
        endcase
      end
    end
  end

  // R2
  miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_fall && !cs_idle) |=> $stable(miso_q));

  // R3
  wel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && phase == PH_OPC && rx_byte == OP_WEL_SET) |=> wel);

  // R7
  wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && (kind == K_MWR || kind == K_SWR)) |=> !wel);

  // R8
  sr_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wel |=> $stable(sr_hi));

  // R12
  skip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP && !cs_idle) |=> (phase == PH_SKIP));
endmodule

// File: rtl/fram_spi_model.sv
module fram_spi_model #(
  parameter int ADDR_W      = 15,
  parameter int STORE_AW    = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic miso
);
  logic                sclk_rise, sclk_fall, cs_idle, cs_rise, mosi_s;
  logic                mem_we;
  logic [STORE_AW-1:0] mem_waddr, mem_raddr;
  logic [7:0]          mem_wdata, mem_rdata;

  initial begin
    assert (STORE_AW <= ADDR_W && ADDR_W > 8 && SYNC_STAGES >= 1);
  end

  fram_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_idle(cs_idle),
    .cs_rise(cs_rise), .mosi_s(mosi_s)
  );

  fram_cmd_ctrl #(.ADDR_W(ADDR_W), .STORE_AW(STORE_AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_idle(cs_idle), .cs_rise(cs_rise), .mosi_s(mosi_s), .miso(miso),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata)
  );

  fram_store #(.AW(STORE_AW), .DW(8)) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );
endmodule

// File: tb/fram_spi_model_tb.sv
module fram_spi_model_tb_top;
  localparam int HALF = 8;

  typedef struct packed {
    logic [15:0] wa;
    logic [15:0] ra;
    logic [7:0]  d;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{16'h0010, 16'h0010, 8'h5A},
    '{16'h8020, 16'h0020, 8'hC3},
    '{16'h0123, 16'h8123, 8'h01},
    '{16'h07FE, 16'h07FE, 8'hFF},
    '{16'h3456, 16'h3456, 8'h80},
    '{16'h1200, 16'h9200, 8'h7E},
    '{16'h0555, 16'h0555, 8'h5C},
    '{16'hC001, 16'h4001, 8'hA5}
  };

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b1, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;
  logic [7:0] rb, rb2, exp_sr;

  always #10 clk = ~clk;

  fram_spi_model dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h exp %02h", req, got, exp);
    end
  endtask

  task automatic sel();
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic desel();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, input int nbits = 8);
    rx = 8'h00;
    for (int i = 7; i >= 8 - nbits; i--) begin
      sclk = 1'b0;
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic op1(input logic [7:0] op);
    logic [7:0] r;
    sel(); xfer(op, r); desel();
  endtask

  task automatic rd_status(output logic [7:0] s);
    logic [7:0] r;
    sel(); xfer(8'h05, r); xfer(8'h00, s); desel();
  endtask

  task automatic wr_byte(input logic [15:0] a, input logic [7:0] d);
    logic [7:0] r;
    sel(); xfer(8'h02, r); xfer(a[15:8], r); xfer(a[7:0], r); xfer(d, r); desel();
  endtask

  task automatic rd_byte(input logic [15:0] a, output logic [7:0] d);
    logic [7:0] r;
    sel(); xfer(8'h03, r); xfer(a[15:8], r); xfer(a[7:0], r); xfer(8'h00, d); desel();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got 00 exp 01");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    exp_sr = 8'h00;

    // R1 reset state
    chk("R1 miso", {7'd0, miso}, 8'h00);
    rd_status(rb); chk("R1 status", rb, 8'h00);

    // R3 / R11
    op1(8'h06);
    rd_status(rb); chk("R3 status", rb, 8'h02);
    sel(); xfer(8'h05, r);
    for (int k = 0; k < 3; k++) begin
      xfer(8'h00, rb); chk("R11 repeat", rb, 8'h02);
    end
    desel();

    // R4
    op1(8'h04);
    rd_status(rb); chk("R4 status", rb, 8'h00);

    // R6 unlatched write discarded
    op1(8'h06); wr_byte(16'h0042, 8'h33);
    wr_byte(16'h0042, 8'h77);
    rd_byte(16'h0042, rb); chk("R6 ignored", rb, 8'h33);

    // R5 / R10 vector table
    for (int v = 0; v < 8; v++) begin
      op1(8'h06);
      wr_byte(VEC[v].wa, VEC[v].d);
    end
    rd_status(rb); chk("R7 after write", rb, 8'h00);
    for (int v = 0; v < 8; v++) begin
      rd_byte(VEC[v].ra, rb); chk("R5 R10 vector", rb, VEC[v].d);
    end

    // R8 status write
    op1(8'h06);
    sel(); xfer(8'h01, r); xfer(8'hFF, r); desel();
    exp_sr = 8'hFC;
    rd_status(rb); chk("R8 R7 status", rb, exp_sr);
    sel(); xfer(8'h01, r); xfer(8'h00, r); desel();
    rd_status(rb); chk("R8 unlatched", rb, exp_sr);

    // R5 / R9 / R2 bursts
    op1(8'h06);
    sel(); xfer(8'h02, r); xfer(8'h01, r); xfer(8'h00, r);
    xfer(8'hA1, r); xfer(8'hB2, r); xfer(8'hC3, r); xfer(8'hD4, r);
    desel();
    sel(); xfer(8'h03, r); xfer(8'h01, r); xfer(8'h00, r);
    xfer(8'h00, rb); chk("R2 R9 burst0", rb, 8'hA1);
    xfer(8'h00, rb); chk("R9 burst1", rb, 8'hB2);
    xfer(8'h00, rb); chk("R9 burst2", rb, 8'hC3);
    xfer(8'h00, rb); chk("R5 burst3", rb, 8'hD4);
    desel();

    // R9 wrap
    op1(8'h06);
    sel(); xfer(8'h02, r); xfer(8'h7F, r); xfer(8'hFF, r);
    xfer(8'h11, r); xfer(8'h22, r); desel();
    sel(); xfer(8'h03, r); xfer(8'h7F, r); xfer(8'hFF, r);
    xfer(8'h00, rb); xfer(8'h00, rb2); desel();
    chk("R9 top", rb, 8'h11);
    chk("R9 wrap", rb2, 8'h22);
    rd_byte(16'h0000, rb); chk("R9 zero", rb, 8'h22);

    // R12 unknown opcode
    op1(8'h06);
    sel(); xfer(8'h9F, rb); chk("R12 miso", rb, 8'h00);
    xfer(8'h02, rb); xfer(8'h00, rb); xfer(8'h10, rb); xfer(8'hEE, rb);
    chk("R12 miso data", rb, 8'h00);
    desel();
    rd_byte(16'h0010, rb); chk("R12 memory", rb, 8'h5A);
    rd_status(rb); chk("R12 latch kept", rb, exp_sr | 8'h02);
    sel(); xfer(8'h04, r); xfer(8'h06, r); desel();
    rd_status(rb); chk("R12 trailing", rb, exp_sr);

    // R13 partial byte
    op1(8'h06);
    sel(); xfer(8'h02, r); xfer(8'h05, r); xfer(8'h55, r); xfer(8'hFF, r, 4); desel();
    rd_byte(16'h0555, rb); chk("R13 partial", rb, 8'h5C);
    rd_status(rb); chk("R7 partial", rb, exp_sr);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule